// File: doc/BRIEF.md
# Glitch-Free Reference Clock Selector

This block drives one reference clock output from one of several free-running candidate clocks. Software picks the candidate, and the block hands the output over without a runt pulse. A change of source happens in two steps. First the outgoing source's enable is removed by flip-flops clocked on that source's own falling edge. Only after that enable is gone does the incoming source's enable rise, synchronised on the incoming source's falling edge. The output is therefore low during the gap between the two sources.

If the outgoing source has stopped toggling, its enable can never fall, and the handover waits forever. A one-shot recovery strobe handles this case. It asynchronously drops every enable flip-flop, and the selected source then comes up through its own synchroniser. A busy flag in the control clock domain tells software whether the most recent selection or recovery has finished. Software is expected to confirm that a candidate clock is running before it selects that candidate, and to use the recovery strobe when the old source is dead.

Top module: `refclk_switch`

## Requirements
- R1: While `sys_rst_n` is low, `busy` is 1 and `clk_out` is 0. After reset, source 0 is selected and drives `clk_out`, and `busy` falls once that source is enabled.
- R2: Once `busy` has fallen after a selection, `clk_out` follows the selected source (index given by binary `sel_src`) with that source's period.
- R3: Every high pulse on `clk_out` lasts exactly one full high phase of one of the candidate clocks. No shortened pulse appears across a handover.
- R4: At most one source is enabled at any time. While no enabled source is toggling, `clk_out` stays low.
- R5: `busy` is 1 in the cycle after a `sel_wr` or `kick_rst` strobe. It stays 1 until the selected source's enable has been seen in the `sys_clk` domain, and it is 0 only while that enable is seen.
- R6: Selecting the source that is already driving leaves `clk_out` unchanged and holds `busy` high for exactly one `sys_clk` cycle.
- R7: If the currently enabled source has stopped low, a selection of another source does not complete. `busy` stays 1 and `clk_out` stays low.
- R8: A one-cycle `kick_rst` strobe produces a single-cycle internal clear that drops all enables. The selected source is then enabled through its own synchroniser, so a stalled handover completes and `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Control clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | NUM_SRC (4) | Candidate clocks, bit i is source i |
| sel_wr | input | 1 | One-cycle strobe: load `sel_src` as the new source |
| sel_src | input | SEL_W (2) | Binary index of the requested source |
| kick_rst | input | 1 | One-cycle strobe: clear all enables (recovery) |
| busy | output | 1 | 1 while a selection or recovery is pending |
| clk_out | output | 1 | Selected reference clock |

## Verification
`busy` rises on the first `sys_clk` edge after a strobe, so the bench samples it at the falling edge that follows that strobe. When the source does not change, `busy` is low again one cycle later, and the bench samples it at the second falling edge. A real handover takes two falling edges of the old clock, two falling edges of the new clock and two `sys_clk` stages, so its length depends on the clock ratios. The scoreboard monitor therefore waits for `busy` to fall and then times two rising edges of `clk_out` against the expected period. A separate pulse watcher times every high phase of the output to catch shortened pulses.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
  localparam int unsigned DEF_NUM_SRC = 4;
  localparam int unsigned DEF_STAGES  = 2;

  function automatic logic [DEF_NUM_SRC-1:0] idx_to_onehot(input int unsigned idx);
    logic [DEF_NUM_SRC-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser with asynchronous clear; STAGES must be >= 2.
module clksw_sync #(
  parameter int unsigned STAGES   = 2,
  parameter bit          NEG_EDGE = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    if (NEG_EDGE) begin : g_fall
      always_ff @(negedge clk or posedge arst) begin
        if (arst) ff <= '0;
        else      ff <= {ff[STAGES-2:0], d};
      end
    end else begin : g_rise
      always_ff @(posedge clk or posedge arst) begin
        if (arst) ff <= '0;
        else      ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/clksw_lane.sv
`timescale 1ns/1ps
// One candidate path: an enable that changes only while its own clock is low.
module clksw_lane #(
  parameter int unsigned STAGES = 2
) (
  input  logic src_clk,
  input  logic clr,
  input  logic want,
  input  logic others_off,
  output logic en,
  output logic gated
);
  logic arm;

  assign arm = want & others_off;

  clksw_sync #(.STAGES(STAGES), .NEG_EDGE(1'b1)) u_en_sync (
    .clk  (src_clk),
    .arst (clr),
    .d    (arm),
    .q    (en)
  );

  assign gated = src_clk & en;
endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
// Control-domain register file: request vector, recovery pulse, busy flag.
module clksw_ctrl #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_wr,
  input  logic [SEL_W-1:0]   sel_src,
  input  logic               kick_rst,
  input  logic [NUM_SRC-1:0] en_seen,
  output logic [NUM_SRC-1:0] want,
  output logic               kick_pulse,
  output logic               busy
);
  logic [NUM_SRC-1:0] want_nxt;

  always_comb begin
    want_nxt = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_src == SEL_W'(i)) want_nxt[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want       <= NUM_SRC'(1);
      kick_pulse <= 1'b0;
      busy       <= 1'b1;
    end else begin
      kick_pulse <= kick_rst;
      if (sel_wr) want <= want_nxt;
      if (sel_wr || kick_rst)          busy <= 1'b1;
      else if (|(want & en_seen))      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/refclk_switch.sv
`timescale 1ns/1ps
module refclk_switch #(
  parameter int unsigned NUM_SRC = clksw_pkg::DEF_NUM_SRC,
  parameter int unsigned STAGES  = clksw_pkg::DEF_STAGES,
  localparam int unsigned SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               sys_clk,
  input  logic               sys_rst_n,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic               sel_wr,
  input  logic [SEL_W-1:0]   sel_src,
  input  logic               kick_rst,
  output logic               busy,
  output logic               clk_out
);
  logic [NUM_SRC-1:0] want;
  logic [NUM_SRC-1:0] lane_en;
  logic [NUM_SRC-1:0] en_seen;
  logic [NUM_SRC-1:0] gated;
  logic               kick_pulse;
  logic               lane_clr;

  assign lane_clr = ~sys_rst_n | kick_pulse;

  clksw_ctrl #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_ctrl (
    .clk        (sys_clk),
    .rst_n      (sys_rst_n),
    .sel_wr     (sel_wr),
    .sel_src    (sel_src),
    .kick_rst   (kick_rst),
    .en_seen    (en_seen),
    .want       (want),
    .kick_pulse (kick_pulse),
    .busy       (busy)
  );

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
      logic [NUM_SRC-1:0] mask;
      assign mask = ~(NUM_SRC'(1) << i);

      clksw_lane #(.STAGES(STAGES)) u_lane (
        .src_clk    (src_clk[i]),
        .clr        (lane_clr),
        .want       (want[i]),
        .others_off (~|(lane_en & mask)),
        .en         (lane_en[i]),
        .gated      (gated[i])
      );

      clksw_sync #(.STAGES(STAGES), .NEG_EDGE(1'b0)) u_seen (
        .clk  (sys_clk),
        .arst (lane_clr),
        .d    (lane_en[i]),
        .q    (en_seen[i])
      );
    end
  endgenerate

  assign clk_out = |gated;
endmodule

// File: rtl/clksw_checker.sv
`timescale 1ns/1ps
module clksw_checker #(
  parameter int unsigned NUM_SRC = 4
) (
  input logic               sys_clk,
  input logic               sys_rst_n,
  input logic               sel_wr,
  input logic               kick_rst,
  input logic               busy,
  input logic [NUM_SRC-1:0] lane_en,
  input logic [NUM_SRC-1:0] want,
  input logic [NUM_SRC-1:0] en_seen,
  input logic               kick_pulse
);
  // R4
  single_enable_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $onehot0(lane_en));

  // R5
  busy_raise_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (sel_wr || kick_rst) |=> busy);

  // R5
  idle_means_live_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !busy |-> |(want & en_seen));

  // R8
  kick_clears_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    kick_pulse |-> (lane_en == '0));

  // R5
  busy_hold_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (busy && !(|(want & en_seen))) |=> busy);
endmodule

bind refclk_switch clksw_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .sys_clk    (sys_clk),
  .sys_rst_n  (sys_rst_n),
  .sel_wr     (sel_wr),
  .kick_rst   (kick_rst),
  .busy       (busy),
  .lane_en    (lane_en),
  .want       (want),
  .en_seen    (en_seen),
  .kick_pulse (kick_pulse)
);

// File: tb/refclk_switch_test.sv
`timescale 1ns/1ps
module refclk_switch_test;
  localparam int N = 4;
  localparam int HALF [N] = '{7, 11, 13, 17};

  logic         sys_clk = 1'b0;
  logic         sys_rst_n = 1'b0;
  logic [N-1:0] src_clk;
  logic [N-1:0] run = '1;
  logic         sel_wr = 1'b0;
  logic [1:0]   sel_src = '0;
  logic         kick_rst = 1'b0;
  logic         busy, clk_out;

  int checks = 0, errors = 0;
  int exp_q[$];
  int pushed = 0, served = 0;
  int runts = 0, rises = 0;
  realtime t_rise = 0;

  always #2.5 sys_clk = ~sys_clk;

  generate
    for (genvar g = 0; g < N; g++) begin : g_src
      logic c = 1'b0;
      initial forever begin
        #(HALF[g]);
        if (run[g] || c) c = ~c;
      end
      assign src_clk[g] = c;
    end
  endgenerate

  refclk_switch uut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .src_clk(src_clk),
    .sel_wr(sel_wr), .sel_src(sel_src), .kick_rst(kick_rst),
    .busy(busy), .clk_out(clk_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse watcher: every high phase must match one source's half period (R3)
  always @(posedge clk_out) begin t_rise = $realtime; rises++; end
  always @(negedge clk_out) begin
    automatic int w = int'(($realtime - t_rise) * 1000.0);
    automatic bit ok = 1'b0;
    for (int j = 0; j < N; j++) if (w == HALF[j] * 1000) ok = 1'b1;
    if (!ok) runts++;
  end

  // scoreboard monitor
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      begin
        automatic int s = exp_q.pop_front();
        automatic realtime t0, t1;
        wait (busy == 1'b0);
        @(posedge clk_out); t0 = $realtime;
        @(posedge clk_out); t1 = $realtime;
        check("R2 period(ps)", int'((t1 - t0) * 1000.0), 2 * HALF[s] * 1000);
        check("R3 runt pulses", runts, 0);
        served++;
      end
    end
  end

  task automatic select_src(input int s, input string req);
    @(negedge sys_clk); sel_wr = 1'b1; sel_src = 2'(s);
    @(negedge sys_clk); sel_wr = 1'b0;
    check({req, " busy after select"}, busy, 1);
  endtask

  task automatic expect_src(input int s);
    exp_q.push_back(s); pushed++;
    wait (served == pushed);
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r0;
    #20;
    // R1 reset state
    check("R1 busy in reset", busy, 1);
    check("R1 clk_out in reset", clk_out, 0);
    @(negedge sys_clk); sys_rst_n = 1'b1;
    // R1 source 0 after reset
    expect_src(0);
    check("R1 busy after start", busy, 0);

    // R5 / R2 ordinary handovers
    select_src(1, "R5"); expect_src(1);
    select_src(3, "R5"); expect_src(3);

    // R6 same source: busy for exactly one cycle
    select_src(3, "R6");
    @(negedge sys_clk);
    check("R6 busy cleared next cycle", busy, 0);
    expect_src(3);

    select_src(2, "R5"); expect_src(2);

    // R7 stalled handover: source 2 stops low
    run[2] = 1'b0;
    #60;
    select_src(0, "R7");
    r0 = rises;
    repeat (300) @(negedge sys_clk);
    check("R7 busy stays set", busy, 1);
    check("R4 clk_out held low during stall", rises - r0, 0);
    check("R7 clk_out low", clk_out, 0);

    // R8 recovery strobe
    @(negedge sys_clk); kick_rst = 1'b1;
    @(negedge sys_clk); kick_rst = 1'b0;
    check("R8 busy after kick", busy, 1);
    expect_src(0);

    // restart source 2 and switch back to it
    run[2] = 1'b1;
    #100;
    select_src(2, "R2"); expect_src(2);
    select_src(1, "R3"); expect_src(1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule